// File: doc/BRIEF.md
# Statistics Counter Bank with Threshold Interrupt

This block keeps a bank of eight 32-bit event counters. Each counter advances by one on every clock cycle in which its own event strobe is high. Software reads any counter through a read address. It reduces a counter by writing a value to it, and that value is subtracted from the current count instead of being loaded. A counter is reduced this way after its value has been read and accounted for, so events that arrive between the read and the write are kept.

A level interrupt warns software before any counter can overflow. The raw condition is high while at least one counter has its top bit set, which means its value is at or above 0x80000000. The condition only goes away once software has reduced every such counter below that value. An enable bit gates the raw condition onto the interrupt output. This bit has a set strobe and a clear strobe, so software can change it without a read-modify-write. The raw level, the gated level and the enable bit are all visible at the ports.

Top module: `stat_bank_irq`

## Requirements
- R1: After reset every counter reads 0, the enable bit is 0, and both the raw and the gated interrupt outputs are 0.
- R2: A counter whose event strobe is high at a rising clock edge reads one higher after that edge. A counter with no strobe and no write keeps its value.
- R3: When the write strobe is high, the addressed counter (address 0 to 7) has the write data subtracted from it at that edge. The other counters are not changed by the write.
- R4: When an event and a write hit the same counter in the same cycle, both take effect: new value = old + 1 - write data.
- R5: All counter arithmetic is modulo 2^32. An increment from 0xFFFFFFFF gives 0, and subtracting more than the current value wraps around.
- R6: `irq_raw_o` is 1 exactly when at least one counter has bit 31 set, that is, a value of at least 0x80000000.
- R7: `irq_raw_o` stays 1 until every counter that has bit 31 set has been reduced below 0x80000000.
- R8: A 1 on `msk_set_i` sets the enable bit at the next edge. `irq_o` equals `irq_raw_o` AND the enable bit.
- R9: A 1 on `msk_clr_i` clears the enable bit at the next edge. If both strobes are high in the same cycle, the clear wins.
- R10: `irq_raw_o` follows the counters whatever the enable bit holds, so the raw status can be read while the interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event strobes, one per counter |
| wr_en_i | input | 1 | Write strobe (subtract from a counter) |
| wr_addr_i | input | 3 | Counter written |
| wr_data_i | input | 32 | Amount to subtract |
| rd_addr_i | input | 3 | Counter read |
| rd_data_o | output | 32 | Value of the counter that is read |
| msk_set_i | input | 1 | Set the interrupt enable |
| msk_clr_i | input | 1 | Clear the interrupt enable |
| msk_en_o | output | 1 | Interrupt enable bit |
| irq_raw_o | output | 1 | Raw threshold interrupt |
| irq_o | output | 1 | Gated threshold interrupt |

## Verification
On every cycle the assertions check each counter's update rule: hold, increment, subtract, and the combined increment and subtract. They also check the effect of the set and clear strobes on the enable bit, and that the gated output never rises without the raw one. The bench scenarios are the only place that shows the threshold behaviour across the bank. These scenarios raise the interrupt when a counter crosses 0x80000000. They keep it high while a second counter is still above the threshold, and show it dropping only after the last such counter is reduced. They also cover wrap-around past zero and past 0xFFFFFFFF. A bench model compares all eight counters and every output after each cycle.

// File: rtl/stat_bank_irq.sv
module stat_bank_irq #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  localparam int ADDR_W = $clog2(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  input  logic               msk_set_i,
  input  logic               msk_clr_i,
  output logic               msk_en_o,
  output logic               irq_raw_o,
  output logic               irq_o
);

  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_CNT-1:0] top_bit;
  logic               msk_q;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic             hit;
    logic [CNT_W-1:0] dec;

    assign hit        = wr_en_i && (wr_addr_i == ADDR_W'(k));
    assign dec        = hit ? wr_data_i : '0;
    assign top_bit[k] = cnt[k][CNT_W-1];

    always_ff @(posedge clk) begin
      if (!rst_n) cnt[k] <= '0;
      else        cnt[k] <= cnt[k] + CNT_W'(evt_i[k]) - dec;
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i[k] && !hit) |=> $stable(cnt[k])); // R2
    AST_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[k] && !hit) |=> (cnt[k] == $past(cnt[k]) + 1'b1)); // R2
    AST_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i[k] && hit) |=> (cnt[k] == $past(cnt[k]) - $past(wr_data_i))); // R3
    AST_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[k] && hit) |=> (cnt[k] == $past(cnt[k]) + 1'b1 - $past(wr_data_i))); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         msk_q <= 1'b0;
    else if (msk_clr_i) msk_q <= 1'b0;
    else if (msk_set_i) msk_q <= 1'b1;
  end

  assign rd_data_o = cnt[rd_addr_i];
  assign irq_raw_o = |top_bit;
  assign msk_en_o  = msk_q;
  assign irq_o     = irq_raw_o & msk_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_set_i && !msk_clr_i) |=> msk_en_o); // R8
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    msk_clr_i |=> !msk_en_o); // R9
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_raw_o && msk_en_o)); // R8
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!msk_set_i && !msk_clr_i) |=> $stable(msk_en_o)); // R9

endmodule

// File: tb/stat_bank_irq_bench.sv
`timescale 1ns/100ps
module stat_bank_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        msk_set = 1'b0, msk_clr = 1'b0;
  logic        msk_en, irq_raw, irq;

  int checks = 0, failures = 0;
  logic [31:0] exp_c [8];
  logic        exp_m;

  always #10 clk = ~clk;

  stat_bank_irq u_stat_bank_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .msk_set_i(msk_set), .msk_clr_i(msk_clr), .msk_en_o(msk_en),
    .irq_raw_o(irq_raw), .irq_o(irq));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic check_all(string req);
    logic raw;
    raw = 1'b0;
    for (int k = 0; k < 8; k++) begin
      rd_addr = 3'(k);
      #0.8;
      chk(req, $sformatf("counter %0d", k), rd_data, exp_c[k]);
      raw |= exp_c[k][31];
    end
    chk(req, "irq_raw", 32'(irq_raw), 32'(raw));
    chk(req, "irq", 32'(irq), 32'(raw & exp_m));
    chk(req, "enable", 32'(msk_en), 32'(exp_m));
  endtask

  task automatic cyc(string req, logic [7:0] ev, logic we, logic [2:0] a,
                     logic [31:0] d, logic ms, logic mc);
    evt = ev; wr_en = we; wr_addr = a; wr_data = d; msk_set = ms; msk_clr = mc;
    @(posedge clk);
    for (int k = 0; k < 8; k++)
      exp_c[k] = exp_c[k] + 32'(ev[k]) - ((we && a == 3'(k)) ? d : 32'd0);
    if (mc) exp_m = 1'b0;
    else if (ms) exp_m = 1'b1;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; msk_set = 1'b0; msk_clr = 1'b0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_c[k] = '0;
    exp_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    for (int i = 0; i < 64; i++) cyc("R2", 8'(i * 29 + 7), 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R2", 8'(1 << (i % 8)), 0, 0, 0, 0, 0);

    for (int a = 0; a < 8; a++) cyc("R3", 8'h00, 1, 3'(a), 32'(a + 1), 0, 0);
    for (int a = 0; a < 8; a++) cyc("R4", 8'hFF, 1, 3'(a), 32'(a * 3 + 2), 0, 0);
    for (int a = 0; a < 8; a++) cyc("R4", 8'(1 << a), 1, 3'(a), 32'd1, 0, 0);

    cyc("R5", 8'h00, 1, 3'd5, exp_c[5] + 32'd1, 0, 0);
    cyc("R5", 8'h20, 0, 0, 0, 0, 0);
    cyc("R5", 8'h00, 1, 3'd5, 32'd5, 0, 0);
    cyc("R5", 8'h00, 1, 3'd5, exp_c[5], 0, 0);

    cyc("R6", 8'h00, 1, 3'd3, exp_c[3] - 32'h7FFF_FFFF, 0, 0);
    cyc("R6", 8'h08, 0, 0, 0, 0, 0);
    cyc("R10", 8'h00, 0, 0, 0, 0, 0);
    cyc("R8", 8'h00, 0, 0, 0, 1, 0);
    cyc("R7", 8'h00, 1, 3'd6, exp_c[6] - 32'h8000_0000, 0, 0);
    cyc("R7", 8'h00, 1, 3'd3, 32'd1, 0, 0);
    cyc("R7", 8'h00, 1, 3'd6, 32'd1, 0, 0);
    cyc("R6", 8'h08, 0, 0, 0, 0, 0);
    cyc("R9", 8'h00, 0, 0, 0, 0, 1);
    cyc("R10", 8'h00, 0, 0, 0, 0, 0);
    cyc("R8", 8'h00, 0, 0, 0, 1, 0);
    cyc("R9", 8'h00, 0, 0, 0, 1, 1);
    cyc("R8", 8'h00, 0, 0, 0, 1, 0);
    cyc("R7", 8'h08, 1, 3'd3, 32'h1000_0000, 0, 0);
    cyc("R9", 8'h00, 0, 0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule